// File: doc/BRIEF.md
# Iterative Integer Divider with Remainder

This unit divides one 64-bit integer by another for a RISC-V style core. It takes an operation code, two operands, a word-mode bit and a fuse bit over a valid/ready handshake. It then runs a radix-2 restoring loop that produces one quotient bit per cycle. It returns the quotient or the remainder. When the fuse bit is set, it also returns the other result of the same division on a second output. Division by zero never traps: it yields fixed values. Decode of instructions and the writeback of results are handled elsewhere.

Signed results round toward zero, and a signed remainder takes the sign of the dividend. Word-mode operations look only at the low 32 bits of each operand. Their 32-bit result is sign-extended to 64 bits, and this includes the unsigned word forms and the divide-by-zero case. The unit resolves divide by zero and signed overflow in a single cycle and does not start the loop for them.

Top module: `div_unit`

## Requirements
- R1: `in_ready` is high only while no operation is held. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_res` and `out_alt` stay unchanged.
- R2: `in_op` = 0 is signed division, with the quotient rounded toward zero.
- R3: `in_op` = 1 is unsigned division.
- R4: `in_op` = 2 returns the signed remainder, which has the sign of the dividend (or is zero). `in_op` = 3 returns the unsigned remainder. The identity dividend = divisor × quotient + remainder holds modulo 2^width.
- R5: With `in_word` = 1, only bits 31:0 of each operand are used. Both outputs carry the 32-bit result sign-extended to 64 bits, for every `in_op`.
- R6: When the divisor is zero (at the operating width), the quotient is all ones and the remainder is the dividend. In word mode these 32-bit values are then sign-extended.
- R7: For signed overflow (the most negative value of the width divided by -1), the quotient is the dividend and the remainder is zero.
- R8: With `in_fuse` = 1, `out_alt` carries the remainder for a divide op and the quotient for a remainder op. With `in_fuse` = 0, `out_alt` is zero.
- R9: `out_valid` rises 65 cycles after the accepting edge for a full-width operation and 33 cycles after it in word mode. For divide by zero and for overflow it rises 1 cycle after that edge.
- R10: While `rst_n` is low and right after its release, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 2 | 0 signed div, 1 unsigned div, 2 signed rem, 3 unsigned rem |
| in_word | input | 1 | 32-bit word mode |
| in_fuse | input | 1 | Also return the other result on out_alt |
| in_a | input | 64 | Dividend |
| in_b | input | 64 | Divisor |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 64 | Requested result |
| out_alt | output | 64 | Companion result when fused, else zero |

## Verification
Small operands are tried with all four sign combinations, which tells truncation toward zero apart from floor rounding and shows which operand gives the remainder its sign. Zero divisors, the most negative value over -1, a zero dividend and a divisor larger than the dividend exercise the early-exit paths and the trivial loop outcomes. The word-mode runs put junk in the upper operand bits and use negative low halves, which separates true 32-bit operation and sign extension from plain truncation of a 64-bit result. Random full-width and small-divisor operands, with random output back-pressure, are compared with a truncating reference model, and each fused result is also checked against the dividend identity.

// File: rtl/div_pkg.sv
// div_pkg: shared types for the iterative divider.
// Assumes op bit 1 selects remainder and op bit 0 selects unsigned.
package div_pkg;
    typedef enum logic [1:0] {
        OP_SDIV = 2'd0,
        OP_UDIV = 2'd1,
        OP_SREM = 2'd2,
        OP_UREM = 2'd3
    } div_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_prep.sv
// div_prep: conditions a request before the loop starts.
// Selects the operating width, takes operand magnitudes, and detects the
// zero-divisor and signed-overflow cases along with their ready results.
// Word dividends are left-aligned so the loop needs only HALF shifts.
module div_prep #(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2,
    localparam int CW = $clog2(XLEN + 1)
) (
    input  logic [1:0]      op,
    input  logic            word,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            neg_q,
    output logic            neg_r,
    output logic [XLEN-1:0] dvd_mag,
    output logic [XLEN-1:0] dvs_mag,
    output logic            special,
    output logic [XLEN-1:0] spec_q,
    output logic [XLEN-1:0] spec_r,
    output logic [CW-1:0]   iters
);
    logic            is_signed, sa, sb, div0, ovf;
    logic [XLEN-1:0] a_w, b_w, ones_w, min_w, a_mag;

    // Width selection and sign extraction for the operating width.
    always_comb begin
        is_signed = ~op[0];
        ones_w    = word ? {{HALF{1'b0}}, {HALF{1'b1}}} : {XLEN{1'b1}};
        min_w     = word ? {{HALF{1'b0}}, 1'b1, {(HALF-1){1'b0}}}
                         : {1'b1, {(XLEN-1){1'b0}}};
        a_w       = a & ones_w;
        b_w       = b & ones_w;
        sa        = is_signed & (word ? a[HALF-1] : a[XLEN-1]);
        sb        = is_signed & (word ? b[HALF-1] : b[XLEN-1]);
    end

    // Magnitudes, loop setup and early-exit results.
    always_comb begin
        div0    = (b_w == '0);
        ovf     = is_signed & (a_w == min_w) & (b_w == ones_w);
        special = div0 | ovf;
        a_mag   = sa ? ((~a_w + 1'b1) & ones_w) : a_w;
        dvs_mag = sb ? ((~b_w + 1'b1) & ones_w) : b_w;
        dvd_mag = word ? {a_mag[HALF-1:0], {HALF{1'b0}}} : a_mag;
        neg_q   = sa ^ sb;
        neg_r   = sa;
        spec_q  = div0 ? ones_w : a_w;
        spec_r  = div0 ? a_w : '0;
        iters   = word ? CW'(HALF) : CW'(XLEN);
    end
endmodule

// File: rtl/div_step.sv
// div_step: one restoring radix-2 iteration, purely combinational.
// Assumes the partial remainder is below the divisor on entry, so the
// shifted value fits in XLEN+1 bits. The quotient bit enters at the LSB
// of the dividend register as its MSB leaves.
module div_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rem_in,
    input  logic [XLEN-1:0] dvd_in,
    input  logic [XLEN-1:0] dvs_in,
    output logic [XLEN-1:0] rem_out,
    output logic [XLEN-1:0] dvd_out
);
    logic [XLEN:0] part, diff;
    logic          fits;

    // Trial subtraction and restore decision.
    always_comb begin
        part    = {rem_in, dvd_in[XLEN-1]};
        diff    = part - {1'b0, dvs_in};
        fits    = ~diff[XLEN];
        rem_out = fits ? diff[XLEN-1:0] : part[XLEN-1:0];
        dvd_out = {dvd_in[XLEN-2:0], fits};
    end
endmodule

// File: rtl/div_finish.sv
// div_finish: applies signs, word sign extension and output selection.
// Assumes the magnitudes come from the loop or from the early-exit path,
// with the negate flags cleared for the latter.
module div_finish #(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2
) (
    input  logic [1:0]      op,
    input  logic            word,
    input  logic            fuse,
    input  logic [XLEN-1:0] q_mag,
    input  logic [XLEN-1:0] r_mag,
    input  logic            neg_q,
    input  logic            neg_r,
    output logic [XLEN-1:0] res,
    output logic [XLEN-1:0] alt
);
    logic [XLEN-1:0] q_s, r_s, q_f, r_f;

    // Sign restore, then width fix-up and result routing.
    always_comb begin
        q_s = neg_q ? (~q_mag + 1'b1) : q_mag;
        r_s = neg_r ? (~r_mag + 1'b1) : r_mag;
        q_f = word ? {{HALF{q_s[HALF-1]}}, q_s[HALF-1:0]} : q_s;
        r_f = word ? {{HALF{r_s[HALF-1]}}, r_s[HALF-1:0]} : r_s;
        res = op[1] ? r_f : q_f;
        alt = fuse ? (op[1] ? q_f : r_f) : '0;
    end
endmodule

// File: rtl/div_unit.sv
// div_unit: iterative divide/remainder unit with valid/ready handshakes.
// Holds one operation at a time: IDLE accepts, BUSY iterates one bit per
// cycle, DONE presents the result until taken. Zero divisor and signed
// overflow go straight to DONE. Synchronous active-low reset.
module div_unit #(
    parameter int XLEN = 64,
    localparam int CW = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_op,
    input  logic            in_word,
    input  logic            in_fuse,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_res,
    output logic [XLEN-1:0] out_alt
);
    import div_pkg::*;

    div_state_e      st;
    logic [CW-1:0]   cnt;
    logic [XLEN-1:0] rem_q, dvd_q, dvs_q;
    logic [1:0]      op_q;
    logic            word_q, fuse_q, negq_q, negr_q;

    logic            p_negq, p_negr, p_special;
    logic [XLEN-1:0] p_dvd, p_dvs, p_sq, p_sr, s_rem, s_dvd;
    logic [CW-1:0]   p_iters;

    div_prep #(.XLEN(XLEN)) prep_i (
        .op(in_op), .word(in_word), .a(in_a), .b(in_b),
        .neg_q(p_negq), .neg_r(p_negr), .dvd_mag(p_dvd), .dvs_mag(p_dvs),
        .special(p_special), .spec_q(p_sq), .spec_r(p_sr), .iters(p_iters)
    );

    div_step #(.XLEN(XLEN)) step_i (
        .rem_in(rem_q), .dvd_in(dvd_q), .dvs_in(dvs_q),
        .rem_out(s_rem), .dvd_out(s_dvd)
    );

    div_finish #(.XLEN(XLEN)) fin_i (
        .op(op_q), .word(word_q), .fuse(fuse_q),
        .q_mag(dvd_q), .r_mag(rem_q), .neg_q(negq_q), .neg_r(negr_q),
        .res(out_res), .alt(out_alt)
    );

    // Handshake flags follow the state directly.
    always_comb begin
        in_ready  = (st == ST_IDLE);
        out_valid = (st == ST_DONE);
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            rem_q  <= '0;
            dvd_q  <= '0;
            dvs_q  <= '0;
            op_q   <= '0;
            word_q <= 1'b0;
            fuse_q <= 1'b0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (in_valid) begin
                    op_q   <= in_op;
                    word_q <= in_word;
                    fuse_q <= in_fuse;
                    if (p_special) begin
                        dvd_q  <= p_sq;
                        rem_q  <= p_sr;
                        negq_q <= 1'b0;
                        negr_q <= 1'b0;
                        st     <= ST_DONE;
                    end else begin
                        dvd_q  <= p_dvd;
                        rem_q  <= '0;
                        dvs_q  <= p_dvs;
                        negq_q <= p_negq;
                        negr_q <= p_negr;
                        cnt    <= p_iters;
                        st     <= ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    rem_q <= s_rem;
                    dvd_q <= s_dvd;
                    cnt   <= cnt - CW'(1);
                    if (cnt == CW'(1)) st <= ST_DONE;
                end
                ST_DONE: if (out_ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/div_unit_chk.sv
// div_unit_chk: protocol and result-shape properties for div_unit.
// Assumes 64-bit default width and the synchronous active-low reset.
module div_unit_chk #(
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [1:0]      in_op,
    input logic            in_word,
    input logic            in_fuse,
    input logic [XLEN-1:0] in_a,
    input logic [XLEN-1:0] in_b,
    input logic            out_valid,
    input logic            out_ready,
    input logic [XLEN-1:0] out_res,
    input logic [XLEN-1:0] out_alt
);
    logic fire, zero_div, sgn_ovf, seen_word, seen_fuse;

    // Request-side classification, independent of the design's decode.
    always_comb begin
        fire     = in_valid & in_ready;
        zero_div = in_word ? (in_b[HALF-1:0] == '0) : (in_b == '0);
        sgn_ovf  = ~in_op[0] & (in_word
                   ? (in_a[HALF-1:0] == {1'b1, {(HALF-1){1'b0}}} && in_b[HALF-1:0] == '1)
                   : (in_a == {1'b1, {(XLEN-1){1'b0}}} && in_b == '1));
    end

    // Remember the mode bits of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_word <= 1'b0;
            seen_fuse <= 1'b0;
        end else if (fire) begin
            seen_word <= in_word;
            seen_fuse <= in_fuse;
        end
    end

    assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    assert_hold_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_alt));
    assert_word_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && seen_word |-> out_res[XLEN-1:HALF] == {HALF{out_res[HALF-1]}}
                                && out_alt[XLEN-1:HALF] == {HALF{out_alt[HALF-1]}});
    assert_zero_div_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire && zero_div |=> out_valid);
    assert_overflow_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire && sgn_ovf |=> out_valid);
    assert_alt_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !seen_fuse |-> out_alt == '0);
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> in_ready && !out_valid);
endmodule

bind div_unit div_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_fuse(in_fuse), .in_a(in_a),
    .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_alt(out_alt)
);

// File: tb/div_unit_tb_top.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares them when the unit hands a result over.
module div_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [1:0]  op;
        logic        word;
        logic        fuse;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] res;
        logic [63:0] alt;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = '0;
    logic        in_word = 1'b0;
    logic        in_fuse = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_res;
    logic [63:0] out_alt;

    int    checks = 0;
    int    fails = 0;
    bit    bp_on = 1'b0;
    item_t sb_q[$];

    div_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_word(in_word), .in_fuse(in_fuse), .in_a(in_a),
        .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_res(out_res), .out_alt(out_alt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: truncating division with the fixed special cases.
    task automatic model(input logic [1:0] op, input logic word, input logic [63:0] a,
                         input logic [63:0] b, output logic [63:0] q, output logic [63:0] r);
        if (word) begin
            logic [31:0] a32, b32, q32, r32;
            int sa, sb;
            a32 = a[31:0]; b32 = b[31:0];
            sa = a32; sb = b32;
            if (b32 == 0) begin q32 = '1; r32 = a32; end
            else if (!op[0] && a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF) begin
                q32 = a32; r32 = 0;
            end else if (!op[0]) begin q32 = sa / sb; r32 = sa % sb; end
            else begin q32 = a32 / b32; r32 = a32 % b32; end
            q = {{32{q32[31]}}, q32};
            r = {{32{r32[31]}}, r32};
        end else begin
            longint la, lb;
            la = a; lb = b;
            if (b == 0) begin q = '1; r = a; end
            else if (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1) begin
                q = a; r = 0;
            end else if (!op[0]) begin q = la / lb; r = la % lb; end
            else begin q = a / b; r = a % b; end
        end
    endtask

    // Driver: queue expectation, hand over request, check busy and latency (R1, R9).
    task automatic send(input logic [1:0] op, input logic word, input logic fuse,
                        input logic [63:0] a, input logic [63:0] b);
        item_t it;
        logic [63:0] q, r;
        int lat;
        logic sp;
        model(op, word, a, b, q, r);
        it.op = op; it.word = word; it.fuse = fuse; it.a = a; it.b = b;
        it.res = op[1] ? r : q;
        it.alt = fuse ? (op[1] ? q : r) : 64'd0;
        sp = word ? (b[31:0] == 0 || (!op[0] && a[31:0] == 32'h8000_0000 && b[31:0] == '1))
                  : (b == 0 || (!op[0] && a == 64'h8000_0000_0000_0000 && b == '1));
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        sb_q.push_back(it);
        in_op = op; in_word = word; in_fuse = fuse; in_a = a; in_b = b; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_a = $urandom; in_b = $urandom;
        check("R1 busy", {63'd0, in_ready}, 64'd0);
        lat = 1;
        while (!out_valid) begin @(negedge clk); lat++; end
        check("R9 latency", 64'(lat), sp ? 64'd1 : (word ? 64'd33 : 64'd65));
    endtask

    // Monitor: compare each handed-over result and the dividend identity (R4).
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R1: unexpected result actual %h expected none", out_res);
            end else begin
                item_t it;
                string tag;
                it = sb_q.pop_front();
                tag = (it.b[31:0] == 0 && (it.word || it.b == 0)) ? "R6 zero div"
                    : it.word ? "R5 word" : (it.op == 2'd0) ? "R2 sdiv"
                    : (it.op == 2'd1) ? "R3 udiv" : "R4 rem";
                check(tag, out_res, it.res);
                check("R8 alt", out_alt, it.alt);
                if (it.fuse) begin
                    logic [63:0] q, r, lhs;
                    q = it.op[1] ? out_alt : out_res;
                    r = it.op[1] ? out_res : out_alt;
                    lhs = it.b * q + r;
                    if (it.word) check("R4 identity word", {32'd0, lhs[31:0]}, {32'd0, it.a[31:0]});
                    else check("R4 identity", lhs, it.a);
                end
            end
        end
    end

    // Output back-pressure, changed away from the sampling edge.
    initial forever begin
        @(posedge clk);
        #2 out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 190000);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] ca[10];
        logic [63:0] cb[10];
        ca[0] = 64'd7;                  cb[0] = 64'd2;
        ca[1] = -64'sd7;                cb[1] = 64'd2;
        ca[2] = 64'd7;                  cb[2] = -64'sd2;
        ca[3] = -64'sd7;                cb[3] = -64'sd2;
        ca[4] = 64'h1234_5678_9ABC_DEF0; cb[4] = 64'd0;
        ca[5] = 64'h8000_0000_0000_0000; cb[5] = '1;
        ca[6] = 64'hFFFF_FFFF_8000_0000; cb[6] = '1;
        ca[7] = 64'd0;                  cb[7] = 64'd5;
        ca[8] = 64'h7FFF_FFFF_FFFF_FFFF; cb[8] = 64'd1;
        ca[9] = 64'd5;                  cb[9] = 64'd7;

        // R10: reset state, during and after reset.
        repeat (3) @(negedge clk);
        check("R10 ready in reset", {63'd0, in_ready}, 64'd1);
        check("R10 valid in reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 ready after reset", {63'd0, in_ready}, 64'd1);
        check("R10 valid after reset", {63'd0, out_valid}, 64'd0);

        // Directed corners across every op, both widths, fused and not (R2-R8).
        for (int w = 0; w < 2; w++)
            for (int o = 0; o < 4; o++)
                for (int k = 0; k < 10; k++)
                    send(2'(o), w[0], k[0],
                         w[0] ? (ca[k] ^ 64'hA5C3_0F96_0000_0000) : ca[k],
                         w[0] ? (cb[k] ^ 64'h3C5A_F069_0000_0000) : cb[k]);

        // Random operands with back-pressure on the output (R1-R5, R8).
        bp_on = 1'b1;
        for (int n = 0; n < 80; n++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = (n % 3 == 0) ? 64'($urandom % 50) : ((n % 3 == 1) ? {$urandom, $urandom}
                                                                 : 64'($urandom));
            if (n % 5 == 0) b = -b;
            send(2'($urandom % 4), n[1], n[0], a, b);
        end

        while (sb_q.size() != 0 || out_valid) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule